// File: doc/BRIEF.md
# Parallel-Port Adapter Register Accessor

This engine lets a host reach one register inside an adapter that bridges a legacy parallel port to a disk interface. It uses only the port's eight data lines, its status lines and its control lines. A single-cycle command carries a register index, a bank flag, a read/write flag, a write value and a transfer mode. The engine runs the matching handshake on the port pins and ends with a one-cycle `done` pulse. For reads, the rebuilt byte appears on `rdata` during that pulse.

Three transfer modes are supported. Mode 0 reads a byte as two nibbles from the status lines. Mode 1 takes five bits from the status lines and three from the control readback. Mode 2 reads all eight data lines after turning them around. Every mode writes a full byte on the data lines. The register index is XOR-scrambled with a key chosen by mode and direction. Every pin step holds for `step_hold` clock cycles, with 0 treated as 1, before the next step begins.

The controller has three states. IDLE accepts a command (transition *accept*). RUN walks a step list that a lookup module selects and advances one step each time the hold timer expires (transition *step*). RUN moves to DONE on the list's end marker (transition *finish*). An invalid mode goes from IDLE to DONE directly (transition *reject*). DONE always returns to IDLE after one cycle (transition *release*).

Top module: `pp_reg_accessor`

## Requirements
- R1: After reset the control lines read 0x04, the data lines read 0x00, and `busy` and `done` are low.
- R2: The effective index is `cmd_index` when `cmd_bank` is 0, and `cmd_index + 0x80` (mod 256) when `cmd_bank` is 1. The key is applied to this effective index.
- R3: A mode-0 read with r = index XOR 0x39 produces these pin states in order, as (data, control): (r, prior), (r,0x01), (r,0x03), (r,0x01), (r,0x04). The data byte is driven a second time while control is 0x03.
- R4: In a mode-0 read, status is sampled once while control is 0x03 (A) and once while control is 0x01 (B). The result is {B[7:4], A[7:4]}.
- R5: A mode-1 read with r = index XOR 0x31 produces (r, prior), (r,0x01), (r&0x37,0x01), (r&0x37,0x03), (r&0x37,0x05), (r|0xF0,0x05), (r|0xF0,0x04).
- R6: In a mode-1 read, status (S) and control readback (K) are sampled while control is 0x05. The result is {K[3:1], S[7:3]}.
- R7: A mode-2 read with r = index XOR 0x29 produces (r, prior), (r,0x01), (r,0x21), (r,0x23), (r,0x04). The result is the data-line input sampled while control is 0x23.
- R8: A write in modes 0 to 2 with r = index XOR 0x19 produces (r, prior), (r,0x01), (value,0x01), (value,0x03), (value,0x04).
- R9: Consecutive pin steps are separated by exactly max(`step_hold`,1) clock cycles.
- R10: `busy` is high from the cycle after an accepted command until the cycle after `done`. `done` lasts one cycle. A command presented while `busy` is high is ignored.
- R11: A mode value of 3 or above causes no pin activity. A read in such a mode returns 0xFF with `done`.
- R12: While idle, the control lines rest at 0x04 and neither the data nor the control lines change. Control only ever takes the values 0x01, 0x03, 0x04, 0x05, 0x21 or 0x23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when `busy` is low |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_bank | input | 1 | 0 = task-file bank, 1 = control bank |
| cmd_index | input | 8 | Register index |
| cmd_wdata | input | 8 | Write value |
| cmd_mode | input | MODE_W | Transfer mode (0, 1, 2 valid) |
| step_hold | input | HOLD_W | Cycles each pin step is held (0 acts as 1) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read result, valid with `done` |
| pp_data_out | output | 8 | Value driven on the port data lines |
| pp_data_in | input | 8 | Port data lines as input |
| pp_status_in | input | 8 | Port status lines |
| pp_ctrl_out | output | 8 | Value written to the port control lines |
| pp_ctrl_in | input | 8 | Control line readback |

## Verification
A wrong step index or a wrong mode lookup shows up at the pins as soon as the first step is taken. The recorded sequence of (data, control) pairs then diverges at the first differing step, within max(`step_hold`,1) cycles of the fault. A wrong sample source, or a sample taken at the wrong control phase, cannot be seen on the pins. It appears only as a wrong `rdata` at `done`, so the bench emulator returns a different status value for each control phase. A hold-timer fault changes the cycle gap between pin changes and is caught on the next step. A state fault that leaks commands during `busy`, or leaves the engine stuck, shows up as an extra pin sequence or a missing `done`.

// File: rtl/pp_acc_pkg.sv
package pp_acc_pkg;

    typedef enum logic [2:0] {
        OP_DATA,
        OP_CTRL,
        OP_SMP_A,
        OP_SMP_B,
        OP_END
    } op_kind_t;

    typedef enum logic [1:0] {
        DV_IDX,
        DV_IDX_AND,
        DV_IDX_OR,
        DV_WVAL
    } dsel_t;

    typedef enum logic [1:0] {
        SRC_STATUS,
        SRC_CTRL,
        SRC_DATA
    } src_t;

    typedef struct packed {
        op_kind_t    kind;
        dsel_t       dsel;
        src_t        src;
        logic [7:0]  ctrl;
    } step_t;

    localparam int STEP_IDX_W = 4;

    function automatic step_t st_data(dsel_t d);
        return '{kind: OP_DATA, dsel: d, src: SRC_STATUS, ctrl: 8'h00};
    endfunction

    function automatic step_t st_ctrl(logic [7:0] v);
        return '{kind: OP_CTRL, dsel: DV_IDX, src: SRC_STATUS, ctrl: v};
    endfunction

    function automatic step_t st_smp(op_kind_t k, src_t s);
        return '{kind: k, dsel: DV_IDX, src: s, ctrl: 8'h00};
    endfunction

    function automatic step_t st_end();
        return '{kind: OP_END, dsel: DV_IDX, src: SRC_STATUS, ctrl: 8'h00};
    endfunction

    function automatic logic [7:0] index_key(logic [1:0] m, logic wr);
        if (wr) return 8'h19;
        unique case (m)
            2'd0:    return 8'h39;
            2'd1:    return 8'h31;
            default: return 8'h29;
        endcase
    endfunction

endpackage

// File: rtl/pp_step_rom.sv
module pp_step_rom
    import pp_acc_pkg::*;
(
    input  logic [1:0]            mode,
    input  logic                  is_write,
    input  logic [STEP_IDX_W-1:0] idx,
    output step_t                 step
);
    always_comb begin
        step = st_end();
        if (is_write) begin
            unique case (idx)
                4'd0:    step = st_data(DV_IDX);
                4'd1:    step = st_ctrl(8'h01);
                4'd2:    step = st_data(DV_WVAL);
                4'd3:    step = st_ctrl(8'h03);
                4'd4:    step = st_ctrl(8'h04);
                default: step = st_end();
            endcase
        end else if (mode == 2'd0) begin
            unique case (idx)
                4'd0:    step = st_data(DV_IDX);
                4'd1:    step = st_ctrl(8'h01);
                4'd2:    step = st_ctrl(8'h03);
                4'd3:    step = st_data(DV_IDX);
                4'd4:    step = st_smp(OP_SMP_A, SRC_STATUS);
                4'd5:    step = st_ctrl(8'h01);
                4'd6:    step = st_smp(OP_SMP_B, SRC_STATUS);
                4'd7:    step = st_ctrl(8'h04);
                default: step = st_end();
            endcase
        end else if (mode == 2'd1) begin
            unique case (idx)
                4'd0:    step = st_data(DV_IDX);
                4'd1:    step = st_ctrl(8'h01);
                4'd2:    step = st_data(DV_IDX_AND);
                4'd3:    step = st_ctrl(8'h03);
                4'd4:    step = st_ctrl(8'h05);
                4'd5:    step = st_data(DV_IDX_OR);
                4'd6:    step = st_smp(OP_SMP_A, SRC_STATUS);
                4'd7:    step = st_smp(OP_SMP_B, SRC_CTRL);
                4'd8:    step = st_ctrl(8'h04);
                default: step = st_end();
            endcase
        end else begin
            unique case (idx)
                4'd0:    step = st_data(DV_IDX);
                4'd1:    step = st_ctrl(8'h01);
                4'd2:    step = st_ctrl(8'h21);
                4'd3:    step = st_ctrl(8'h23);
                4'd4:    step = st_smp(OP_SMP_A, SRC_DATA);
                4'd5:    step = st_ctrl(8'h04);
                default: step = st_end();
            endcase
        end
    end
endmodule

// File: rtl/pp_byte_join.sv
module pp_byte_join (
    input  logic [1:0] mode,
    input  logic [7:0] frag_a,
    input  logic [7:0] frag_b,
    output logic [7:0] value
);
    always_comb begin
        unique case (mode)
            2'd0:    value = {frag_b[7:4], frag_a[7:4]};
            2'd1:    value = {frag_b[3:1], frag_a[7:3]};
            default: value = frag_a;
        endcase
    end
endmodule

// File: rtl/pp_hold_timer.sv
module pp_hold_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] hold,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clr)              cnt_q <= '0;
        else if (load)             cnt_q <= (hold == '0) ? '0 : hold - W'(1);
        else if (cnt_q != '0)      cnt_q <= cnt_q - W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pp_reg_accessor.sv
module pp_reg_accessor
    import pp_acc_pkg::*;
#(
    parameter int HOLD_W = 4,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic              cmd_bank,
    input  logic [7:0]        cmd_index,
    input  logic [7:0]        cmd_wdata,
    input  logic [MODE_W-1:0] cmd_mode,
    input  logic [HOLD_W-1:0] step_hold,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rdata,
    output logic [7:0]        pp_data_out,
    input  logic [7:0]        pp_data_in,
    input  logic [7:0]        pp_status_in,
    output logic [7:0]        pp_ctrl_out,
    input  logic [7:0]        pp_ctrl_in
);
    localparam logic [7:0] BANK_OFFSET = 8'h80;
    localparam logic [7:0] CTRL_REST   = 8'h04;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_t;

    state_t                 state_q, state_d;
    logic [1:0]             mode_q;
    logic                   wr_q;
    logic [7:0]             key_idx_q;
    logic [7:0]             wval_q;
    logic [STEP_IDX_W-1:0]  idx_q;
    logic [7:0]             frag_a_q, frag_b_q;
    logic [7:0]             data_q, ctrl_q, rdata_q;

    logic                   accept, mode_ok, tick, tmr_load;
    logic [7:0]             eff_index, sampled, data_sel, joined;
    step_t                  step;

    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign mode_ok   = (cmd_mode < MODE_W'(3));
    assign eff_index = cmd_index + (cmd_bank ? BANK_OFFSET : 8'h00);

    pp_step_rom rom_i (
        .mode     (mode_q),
        .is_write (wr_q),
        .idx      (idx_q),
        .step     (step)
    );

    pp_byte_join join_i (
        .mode   (mode_q),
        .frag_a (frag_a_q),
        .frag_b (frag_b_q),
        .value  (joined)
    );

    pp_hold_timer #(.W(HOLD_W)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .load    (tmr_load),
        .hold    (step_hold),
        .expired (tick)
    );

    assign tmr_load = (state_q == ST_RUN) && tick && (step.kind != OP_END);

    always_comb begin
        unique case (step.src)
            SRC_CTRL: sampled = pp_ctrl_in;
            SRC_DATA: sampled = pp_data_in;
            default:  sampled = pp_status_in;
        endcase
        unique case (step.dsel)
            DV_IDX_AND: data_sel = key_idx_q & 8'h37;
            DV_IDX_OR:  data_sel = key_idx_q | 8'hF0;
            DV_WVAL:    data_sel = wval_q;
            default:    data_sel = key_idx_q;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = mode_ok ? ST_RUN : ST_DONE;
            ST_RUN:  if (tick && step.kind == OP_END) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            wr_q      <= 1'b0;
            key_idx_q <= '0;
            wval_q    <= '0;
            idx_q     <= '0;
            frag_a_q  <= '0;
            frag_b_q  <= '0;
            data_q    <= '0;
            ctrl_q    <= CTRL_REST;
            rdata_q   <= '0;
        end else if (accept) begin
            mode_q    <= cmd_mode[1:0];
            wr_q      <= cmd_write;
            key_idx_q <= eff_index ^ index_key(cmd_mode[1:0], cmd_write);
            wval_q    <= cmd_wdata;
            idx_q     <= '0;
            if (!mode_ok && !cmd_write) rdata_q <= 8'hFF;
        end else if (state_q == ST_RUN && tick) begin
            idx_q <= idx_q + STEP_IDX_W'(1);
            unique case (step.kind)
                OP_DATA:  data_q   <= data_sel;
                OP_CTRL:  ctrl_q   <= step.ctrl;
                OP_SMP_A: frag_a_q <= sampled;
                OP_SMP_B: frag_b_q <= sampled;
                default:  if (!wr_q) rdata_q <= joined;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = (state_q == ST_DONE);
    assign rdata       = rdata_q;
    assign pp_data_out = data_q;
    assign pp_ctrl_out = ctrl_q;
endmodule

// File: rtl/pp_reg_accessor_chk.sv
module pp_reg_accessor_chk #(
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_write,
    input logic [MODE_W-1:0] cmd_mode,
    input logic              busy,
    input logic              done,
    input logic [7:0]        rdata,
    input logic [7:0]        pp_data_out,
    input logic [7:0]        pp_ctrl_out
);
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_release_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    assert_invalid_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !cmd_write && cmd_mode >= MODE_W'(3)) |=> (done && rdata == 8'hFF));

    assert_idle_rest_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> pp_ctrl_out == 8'h04);

    assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(pp_ctrl_out) && $stable(pp_data_out)));

    assert_ctrl_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pp_ctrl_out inside {8'h01, 8'h03, 8'h04, 8'h05, 8'h21, 8'h23});
endmodule

bind pp_reg_accessor pp_reg_accessor_chk #(.MODE_W(MODE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_write   (cmd_write),
    .cmd_mode    (cmd_mode),
    .busy        (busy),
    .done        (done),
    .rdata       (rdata),
    .pp_data_out (pp_data_out),
    .pp_ctrl_out (pp_ctrl_out)
);

// File: tb/pp_reg_accessor_tb_top.sv
`timescale 1ns/1ps
module pp_reg_accessor_tb_top;
    localparam int HW = 4;
    localparam int MW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_valid, cmd_write, cmd_bank;
    logic [7:0]    cmd_index, cmd_wdata;
    logic [MW-1:0] cmd_mode;
    logic [HW-1:0] step_hold;
    logic          busy, done;
    logic [7:0]    rdata, pp_data_out, pp_data_in, pp_status_in, pp_ctrl_out, pp_ctrl_in;

    logic [7:0] emu_sa, emu_sb, emu_s5, emu_krb, emu_dv;

    int n_total = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pp_reg_accessor #(.HOLD_W(HW), .MODE_W(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_bank(cmd_bank), .cmd_index(cmd_index), .cmd_wdata(cmd_wdata),
        .cmd_mode(cmd_mode), .step_hold(step_hold), .busy(busy), .done(done),
        .rdata(rdata), .pp_data_out(pp_data_out), .pp_data_in(pp_data_in),
        .pp_status_in(pp_status_in), .pp_ctrl_out(pp_ctrl_out), .pp_ctrl_in(pp_ctrl_in)
    );

    // adapter emulator: a distinct status value per control phase
    always_comb begin
        unique case (pp_ctrl_out)
            8'h03:   pp_status_in = emu_sa;
            8'h01:   pp_status_in = emu_sb;
            8'h05:   pp_status_in = emu_s5;
            default: pp_status_in = 8'h00;
        endcase
        pp_ctrl_in = emu_krb;
        pp_data_in = (pp_ctrl_out == 8'h23) ? emu_dv : 8'h5A;
    end

    // pin-change recorder
    logic        rec_on = 1'b0;
    logic [15:0] ev [0:31];
    int          ev_gap [0:31];
    int          ev_n;
    logic [15:0] prev;
    int          last_cyc;

    always @(negedge clk) begin
        if (rec_on && {pp_data_out, pp_ctrl_out} != prev) begin
            if (ev_n < 32) begin
                ev[ev_n]     = {pp_data_out, pp_ctrl_out};
                ev_gap[ev_n] = cyc - last_cyc;
            end
            ev_n     = ev_n + 1;
            prev     = {pp_data_out, pp_ctrl_out};
            last_cyc = cyc;
        end
    end

    logic [15:0] xp [0:31];
    int          xn;
    logic [15:0] xlast;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic xbegin();
        xn    = 0;
        xlast = {pp_data_out, pp_ctrl_out};
    endtask

    task automatic xpush(input logic [7:0] d, input logic [7:0] c);
        if ({d, c} != xlast) begin
            xp[xn] = {d, c};
            xn++;
            xlast  = {d, c};
        end
    endtask

    task automatic rec_begin();
        ev_n     = 0;
        prev     = {pp_data_out, pp_ctrl_out};
        last_cyc = cyc;
        rec_on   = 1'b1;
    endtask

    task automatic issue(input bit wr, input bit bank, input logic [7:0] idx,
                         input logic [7:0] wd, input logic [MW-1:0] m);
        cmd_write = wr; cmd_bank = bank; cmd_index = idx; cmd_wdata = wd; cmd_mode = m;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output bit got, output logic [7:0] rd);
        got = 1'b0; rd = 8'h00;
        for (int i = 0; i < 400 && !got; i++) begin
            if (done) begin got = 1'b1; rd = rdata; end
            else @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic check_seq(input string req);
        bit ok = (ev_n == xn);
        int bad = 0;
        for (int i = 0; i < xn && i < 32; i++)
            if (ok && ev[i] != xp[i]) begin ok = 1'b0; bad = i; end
        if (ev_n != xn) check(1'b0, req, "pin step count", ev_n, xn);
        else check(ok, req, "pin sequence (data,ctrl)", int'(ev[bad]), int'(xp[bad]));
    endtask

    task automatic check_gap(input string req, input int hold);
        int mn = 1000;
        int exp = (hold == 0) ? 1 : hold;
        for (int i = 1; i < ev_n && i < 32; i++) if (ev_gap[i] < mn) mn = ev_gap[i];
        check(mn == exp, req, "minimum step spacing", mn, exp);
    endtask

    task automatic run_read(input bit bank, input logic [7:0] idx, input logic [MW-1:0] m,
                            input int hold, output logic [7:0] rd);
        bit got;
        step_hold = HW'(hold);
        rec_begin();
        issue(1'b0, bank, idx, 8'h00, m);
        wait_done(got, rd);
        rec_on = 1'b0;
        check(got, "R10", "done seen", got, 1);
    endtask

    task automatic t_nibble(input bit bank, input logic [7:0] idx, input logic [7:0] sa,
                            input logic [7:0] sb, input int hold);
        logic [7:0] r, rd;
        emu_sa = sa; emu_sb = sb;
        r = (idx + (bank ? 8'h80 : 8'h00)) ^ 8'h39;
        xbegin();
        xpush(r, 8'h04); xpush(r, 8'h01); xpush(r, 8'h03); xpush(r, 8'h01); xpush(r, 8'h04);
        run_read(bank, idx, 3'd0, hold, rd);
        check_seq(bank ? "R3/R2" : "R3");
        check(rd == {sb[7:4], sa[7:4]}, "R4", "nibble result", rd, {sb[7:4], sa[7:4]});
        check_gap("R9", hold);
        check(pp_ctrl_out == 8'h04, "R12", "control at rest", pp_ctrl_out, 8'h04);
    endtask

    task automatic t_split53(input bit bank, input logic [7:0] idx, input logic [7:0] s5,
                             input logic [7:0] krb, input int hold);
        logic [7:0] r, rd;
        emu_s5 = s5; emu_krb = krb;
        r = (idx + (bank ? 8'h80 : 8'h00)) ^ 8'h31;
        xbegin();
        xpush(r, 8'h04); xpush(r, 8'h01); xpush(r & 8'h37, 8'h01); xpush(r & 8'h37, 8'h03);
        xpush(r & 8'h37, 8'h05); xpush(r | 8'hF0, 8'h05); xpush(r | 8'hF0, 8'h04);
        run_read(bank, idx, 3'd1, hold, rd);
        check_seq(bank ? "R5/R2" : "R5");
        check(rd == {krb[3:1], s5[7:3]}, "R6", "5/3 result", rd, {krb[3:1], s5[7:3]});
        check_gap("R9", hold);
    endtask

    task automatic t_byte(input logic [7:0] idx, input logic [7:0] dv, input int hold);
        logic [7:0] r, rd;
        emu_dv = dv;
        r = idx ^ 8'h29;
        xbegin();
        xpush(r, 8'h04); xpush(r, 8'h01); xpush(r, 8'h21); xpush(r, 8'h23); xpush(r, 8'h04);
        run_read(1'b0, idx, 3'd2, hold, rd);
        check_seq("R7");
        check(rd == dv, "R7", "byte result", rd, dv);
        check_gap("R9", hold);
    endtask

    task automatic t_write(input bit bank, input logic [7:0] idx, input logic [7:0] v,
                           input logic [MW-1:0] m, input int hold);
        logic [7:0] r, rd;
        bit got;
        r = (idx + (bank ? 8'h80 : 8'h00)) ^ 8'h19;
        xbegin();
        xpush(r, 8'h04); xpush(r, 8'h01); xpush(v, 8'h01); xpush(v, 8'h03); xpush(v, 8'h04);
        step_hold = HW'(hold);
        rec_begin();
        issue(1'b1, bank, idx, v, m);
        wait_done(got, rd);
        rec_on = 1'b0;
        check(got, "R8", "write done", got, 1);
        check_seq(bank ? "R8/R2" : "R8");
        check_gap("R9", hold);
    endtask

    task automatic t_invalid();
        logic [7:0] rd;
        run_read(1'b0, 8'h12, 3'd3, 2, rd);
        check(rd == 8'hFF, "R11", "invalid-mode read data", rd, 8'hFF);
        check(ev_n == 0, "R11", "pin steps in invalid read", ev_n, 0);
        begin
            bit got;
            rec_begin();
            issue(1'b1, 1'b0, 8'h07, 8'hC3, 3'd7);
            wait_done(got, rd);
            rec_on = 1'b0;
            check(got, "R11", "invalid-mode write done", got, 1);
            check(ev_n == 0, "R11", "pin steps in invalid write", ev_n, 0);
        end
    endtask

    task automatic t_busy_ignore();
        logic [7:0] r, rd;
        bit got;
        int extra = 0;
        emu_dv = 8'h3C;
        r = 8'h44 ^ 8'h29;
        xbegin();
        xpush(r, 8'h04); xpush(r, 8'h01); xpush(r, 8'h21); xpush(r, 8'h23); xpush(r, 8'h04);
        step_hold = HW'(2);
        rec_begin();
        issue(1'b0, 1'b0, 8'h44, 8'h00, 3'd2);
        // command offered while busy: must be dropped
        issue(1'b1, 1'b1, 8'h11, 8'hEE, 3'd0);
        issue(1'b1, 1'b1, 8'h11, 8'hEE, 3'd0);
        wait_done(got, rd);
        for (int i = 0; i < 20; i++) begin
            if (busy || done) extra++;
            @(negedge clk);
        end
        rec_on = 1'b0;
        check(got, "R10", "done after busy-time command", got, 1);
        check_seq("R10");
        check(extra == 0, "R10", "activity after done", extra, 0);
        check(rd == 8'h3C, "R10", "read data unaffected", rd, 8'h3C);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_bank = 1'b0;
        cmd_index = '0; cmd_wdata = '0; cmd_mode = '0; step_hold = HW'(1);
        emu_sa = 8'h00; emu_sb = 8'h00; emu_s5 = 8'h00; emu_krb = 8'h00; emu_dv = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pp_ctrl_out == 8'h04, "R1", "reset control", pp_ctrl_out, 8'h04);
        check(pp_data_out == 8'h00, "R1", "reset data", pp_data_out, 8'h00);
        check(!busy, "R1", "reset busy", busy, 0);
        check(!done, "R1", "reset done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        t_nibble(1'b0, 8'h02, 8'hA7, 8'h5C, 1);
        t_nibble(1'b1, 8'h06, 8'h3F, 8'hE1, 3);
        t_split53(1'b0, 8'h07, 8'hB8, 8'h0B, 2);
        t_split53(1'b1, 8'h05, 8'h4F, 8'h06, 0);
        t_byte(8'h01, 8'h96, 1);
        t_byte(8'hFF, 8'h00, 4);
        t_write(1'b0, 8'h02, 8'hAA, 3'd0, 1);
        t_write(1'b1, 8'h06, 8'h08, 3'd2, 5);
        t_write(1'b0, 8'h03, 8'h55, 3'd1, 2);
        t_invalid();
        t_busy_ignore();

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule